// File: doc/BRIEF.md
# Wakeup Request Holder with Selectable Clear Source

This block keeps one wakeup request per line for an always-on low-power domain. A line's request is set by its wakeup trigger. How it is later released depends on a per-line pend-mask bit and a 2-bit clear-source field.

With the mask bit at 0, the request releases by itself. On a configurable line it drops a fixed number of clock cycles after the most recent trigger. On a direct line it drops when the direct input goes low.

With the mask bit at 1, the request waits for a pulse from one of four external clear sources. The sources are two DMA channel events and two timer outputs, and the line's select field picks which one.

Configuration is written through a small register write port. A clear-configuration command returns chosen lines to the automatic mode. Edge detection of the triggers and the logic behind the clear-source pulses sit outside this block.

Top module: `wkp_pend_top`

## Requirements
- R1: While `rst_i` is high and in the first cycle after it, `wake_o` is all zeros, every pend-mask bit is 0 and every select field is 00.
- R2: A trigger on a line (`trig_i[n]` high at a clock edge) makes `wake_o[n]` high from that edge on, in every mode. A line with no request and no trigger stays low.
- R3: On a configurable line (`line_direct_i[n]`=0) with mask 0, the request stays high for exactly AUTO_DELAY cycles after the last trigger (default 4), then clears. While the line is in external-clear mode this count is frozen.
- R4: A new trigger on a configurable line with mask 0 while the request is already high keeps it high and restarts the AUTO_DELAY count.
- R5: On a direct line (`line_direct_i[n]`=1) with mask 0, `wake_o[n]` equals `trig_i[n]` one cycle later, so the request drops in the cycle after the input is released.
- R6: With mask 1, the request stays high until the selected source pulses. The select encoding is 00 for `clr_src_i[0]` (DMA channel A), 01 for `clr_src_i[1]` (DMA channel B), 10 for `clr_src_i[2]` (timer A) and 11 for `clr_src_i[3]` (timer B). Pulses on unselected sources have no effect.
- R7: Write map (`wr_addr_i`):
  - 0 loads the pend-mask bits, with data bit n for line n.
  - 1 loads the select fields of lines 0..15, line n at data bits 2n+1:2n.
  - 2 loads the select fields of lines 16..31, line n at data bits 2(n-16)+1:2(n-16).
  - 3 clears configuration: every line whose data bit is 1 gets mask 0 and select 00.
- R8: When a trigger and the selected clear pulse arrive in the same cycle, the trigger wins and the request stays high.
- R9: A direct line with mask 1 keeps its request after the direct input is released, until the selected source pulses.
- R10: A configuration write takes effect from the cycle after the write. A trigger in the cycle of the write is handled with the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | N_LINES | Per-line trigger: edge pulse on configurable lines, input level on direct lines |
| line_direct_i | input | N_LINES | 1 marks a direct line, 0 a configurable line |
| clr_src_i | input | 4 | Clear-source pulses: DMA A, DMA B, timer A, timer B |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (see R7) |
| wr_data_i | input | DATA_W | Write data |
| wake_o | output | N_LINES | Per-line wakeup request |

## Verification
Several properties are checked on every cycle and every line:
- a trigger sets the request, and a request never rises without one;
- a direct unmasked line drops after release;
- a masked line holds unless its selected source pulses, and drops when that source pulses without a trigger;
- a clear-configuration write zeroes the line's settings.

The exact AUTO_DELAY run length, its restart on retrigger and the timing of writes against triggers are shown only by the bench. The bench compares `wake_o` every cycle against a model computed from the requirements, in directed cases and under random traffic.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

    localparam int unsigned SRC_COUNT      = 4;
    localparam int unsigned LINES_PER_SREG = 16;
    localparam int unsigned SEL_W          = 2;

    // Register select on the write port
    typedef enum logic [1:0] {
        REG_MASK    = 2'd0,
        REG_SEL_LO  = 2'd1,
        REG_SEL_HI  = 2'd2,
        REG_CLR_CFG = 2'd3
    } wkp_reg_e;

    // External clear-source code, the index into clr_src_i
    typedef enum logic [SEL_W-1:0] {
        SRC_DMA_A = 2'd0,
        SRC_DMA_B = 2'd1,
        SRC_TMR_A = 2'd2,
        SRC_TMR_B = 2'd3
    } wkp_src_e;

    // How a pending request is released
    typedef enum logic [1:0] {
        CLR_AUTO_DELAY,
        CLR_RELEASE,
        CLR_EXTERNAL
    } wkp_clr_mode_e;

    typedef struct packed {
        logic     ext_clr;   // pend-mask bit
        wkp_src_e src;       // selected clear source
    } wkp_line_cfg_t;

    function automatic wkp_clr_mode_e clr_mode(input wkp_line_cfg_t cfg, input logic direct);
        if (cfg.ext_clr) return CLR_EXTERNAL;
        if (direct)      return CLR_RELEASE;
        return CLR_AUTO_DELAY;
    endfunction

    function automatic logic src_pulse(input logic [SRC_COUNT-1:0] pulses, input wkp_src_e s);
        return pulses[s];
    endfunction

endpackage

// File: rtl/wkp_cfg_regs.sv
module wkp_cfg_regs
    import wkp_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             wr_en_i,
    input  logic [1:0]                       wr_addr_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output wkp_line_cfg_t [N_LINES-1:0]      cfg_o
);

    wkp_reg_e addr;
    assign addr = wkp_reg_e'(wr_addr_i);

    for (genvar n = 0; n < N_LINES; n++) begin : g_line
        localparam int unsigned FLD = (n % LINES_PER_SREG) * SEL_W;
        localparam wkp_reg_e    SEL_REG = (n >= LINES_PER_SREG) ? REG_SEL_HI : REG_SEL_LO;

        wkp_line_cfg_t cfg_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                cfg_q <= '0;
            end else if (wr_en_i) begin
                if (addr == REG_MASK) begin
                    cfg_q.ext_clr <= wr_data_i[n];
                end else if (addr == REG_CLR_CFG) begin
                    if (wr_data_i[n]) cfg_q <= '0;
                end else if (addr == SEL_REG) begin
                    cfg_q.src <= wkp_src_e'(wr_data_i[FLD +: SEL_W]);
                end
            end
        end

        assign cfg_o[n] = cfg_q;
    end

endmodule

// File: rtl/wkp_line.sv
module wkp_line
    import wkp_pkg::*;
#(
    parameter int unsigned AUTO_DELAY = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 trig_i,
    input  logic                 direct_i,
    input  wkp_line_cfg_t        cfg_i,
    input  logic [SRC_COUNT-1:0] clr_src_i,
    output logic                 req_o
);

    localparam int unsigned     CW   = (AUTO_DELAY > 1) ? $clog2(AUTO_DELAY) : 1;
    localparam logic [CW-1:0]   LOAD = CW'(AUTO_DELAY - 1);

    wkp_clr_mode_e mode;
    logic          ext_hit;
    logic          req_q;
    logic [CW-1:0] cnt_q;

    assign mode    = clr_mode(cfg_i, direct_i);
    assign ext_hit = src_pulse(clr_src_i, cfg_i.src);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q <= 1'b0;
            cnt_q <= '0;
        end else if (trig_i) begin
            // a trigger always wins over any clear condition
            req_q <= 1'b1;
            cnt_q <= LOAD;
        end else if (req_q) begin
            unique case (mode)
                CLR_AUTO_DELAY: begin
                    if (cnt_q == '0) req_q <= 1'b0;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                CLR_RELEASE:  req_q <= 1'b0;
                CLR_EXTERNAL: if (ext_hit) req_q <= 1'b0;
                default:      req_q <= req_q;
            endcase
        end
    end

    assign req_o = req_q;

endmodule

// File: rtl/wkp_pend_top.sv
module wkp_pend_top
    import wkp_pkg::*;
#(
    parameter int unsigned N_LINES    = 32,
    parameter int unsigned AUTO_DELAY = 4,
    parameter int unsigned DATA_W     = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [N_LINES-1:0]   trig_i,
    input  logic [N_LINES-1:0]   line_direct_i,
    input  logic [3:0]           clr_src_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic [N_LINES-1:0]   wake_o
);

    wkp_line_cfg_t [N_LINES-1:0] cfg;

    wkp_cfg_regs #(
        .N_LINES (N_LINES),
        .DATA_W  (DATA_W)
    ) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg)
    );

    for (genvar n = 0; n < N_LINES; n++) begin : g_ln
        wkp_line #(
            .AUTO_DELAY (AUTO_DELAY)
        ) u_line (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .trig_i    (trig_i[n]),
            .direct_i  (line_direct_i[n]),
            .cfg_i     (cfg[n]),
            .clr_src_i (clr_src_i),
            .req_o     (wake_o[n])
        );
    end

endmodule

// File: rtl/wkp_pend_chk.sv
module wkp_pend_chk
    import wkp_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic [N_LINES-1:0]           trig_i,
    input  logic [N_LINES-1:0]           line_direct_i,
    input  logic [3:0]                   clr_src_i,
    input  logic                         wr_en_i,
    input  logic [1:0]                   wr_addr_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  wkp_line_cfg_t [N_LINES-1:0]  cfg_i,
    input  logic [N_LINES-1:0]           wake_o
);

    for (genvar n = 0; n < N_LINES; n++) begin : g_chk
        // R2: trigger sets the request
        p_trig_sets_r2: assert property (@(posedge clk_i) disable iff (rst_i)
            trig_i[n] |=> wake_o[n]);

        // R2: no request appears without a trigger
        p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (rst_i)
            (!wake_o[n] && !trig_i[n]) |=> !wake_o[n]);

        // R5: direct unmasked line drops after release
        p_direct_release_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            (!cfg_i[n].ext_clr && line_direct_i[n] && !trig_i[n]) |=> !wake_o[n]);

        // R6: masked line holds unless its selected source pulses
        p_ext_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
            (cfg_i[n].ext_clr && wake_o[n] && !clr_src_i[cfg_i[n].src]) |=> wake_o[n]);

        // R6: selected source clears a masked line when no trigger is present
        p_ext_clear_r6: assert property (@(posedge clk_i) disable iff (rst_i)
            (cfg_i[n].ext_clr && wake_o[n] && clr_src_i[cfg_i[n].src] && !trig_i[n]) |=> !wake_o[n]);

        // R7: clear-configuration command zeroes the line's settings
        p_cfg_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
            (wr_en_i && wr_addr_i == 2'd3 && wr_data_i[n]) |=> (cfg_i[n] == '0));
    end

endmodule

bind wkp_pend_top wkp_pend_chk #(
    .N_LINES (N_LINES),
    .DATA_W  (DATA_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .trig_i        (trig_i),
    .line_direct_i (line_direct_i),
    .clr_src_i     (clr_src_i),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .cfg_i         (cfg),
    .wake_o        (wake_o)
);

// File: tb/tb_wkp_pend_top.sv
module tb_wkp_pend_top;

    localparam int N     = 32;
    localparam int DELAY = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  trig = '0;
    logic [N-1:0]  dir_v = '0;
    logic [3:0]    clr = '0;
    logic          we = 1'b0;
    logic [1:0]    wa = '0;
    logic [31:0]   wd = '0;
    logic [N-1:0]  wake;

    int total = 0;
    int bad   = 0;
    string tag = "R1";
    logic [N-1:0] smp;

    // bench model state
    logic [N-1:0] m_req;
    logic [N-1:0] m_mask;
    logic [1:0]   m_sel [N];
    int           m_rem [N];

    wkp_pend_top #(.N_LINES(N), .AUTO_DELAY(DELAY), .DATA_W(32)) dut (
        .clk_i(clk), .rst_i(rst), .trig_i(trig), .line_direct_i(dir_v),
        .clr_src_i(clr), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .wake_o(wake)
    );

    always #5 clk = ~clk;

    // Expected behaviour from the requirements, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_req  = '0;
            m_mask = '0;
            for (int n = 0; n < N; n++) begin m_sel[n] = 2'b00; m_rem[n] = 0; end
        end else begin
            for (int n = 0; n < N; n++) begin
                if (trig[n]) begin
                    m_req[n] = 1'b1;                         // R2, R8
                    m_rem[n] = DELAY;
                end else if (m_req[n]) begin
                    if (m_mask[n]) begin
                        if (clr[m_sel[n]]) m_req[n] = 1'b0;   // R6, R9
                    end else if (dir_v[n]) begin
                        m_req[n] = 1'b0;                     // R5
                    end else begin
                        m_rem[n] = m_rem[n] - 1;             // R3, R4
                        if (m_rem[n] == 0) m_req[n] = 1'b0;
                    end
                end
            end
            if (we) begin                                    // R7, R10
                for (int n = 0; n < N; n++) begin
                    case (wa)
                        2'd0: m_mask[n] = wd[n];
                        2'd1: if (n < 16) m_sel[n] = wd[2*n +: 2];
                        2'd2: if (n >= 16) m_sel[n] = wd[2*(n-16) +: 2];
                        default: if (wd[n]) begin m_mask[n] = 1'b0; m_sel[n] = 2'b00; end
                    endcase
                end
            end
        end
    end

    task automatic chk_vec(input string t, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: wake actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string t, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // one cycle: sample and compare at the falling edge, then drive new inputs
    task automatic cyc(input logic [N-1:0] t, input logic [3:0] c,
                       input logic w, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        smp = wake;
        chk_vec(tag, wake, m_req);
        trig = t; clr = c; we = w; wa = a; wd = d;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc('0, 4'h0, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cyc('0, 4'h0, 1'b1, a, d);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int run;
        void'($urandom(32'h5eed_0042));

        // R1: reset state
        tag = "R1";
        idle(3);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk_vec("R1 after reset", wake, '0);
        idle(2);

        // R3: single pulse on configurable line 2 stays high exactly DELAY cycles
        tag = "R3";
        cyc(32'h4, 4'h0, 1'b0, 2'd0, 32'h0);
        run = 0;
        for (int i = 0; i < 8; i++) begin cyc('0, 4'h0, 1'b0, 2'd0, 32'h0); run += int'(smp[2]); end
        chk_int("R3 high run length", run, DELAY);

        // R4: retrigger restarts the count (expected run 3 + DELAY)
        tag = "R4";
        cyc(32'h4, 4'h0, 1'b0, 2'd0, 32'h0);
        run = 0;
        cyc('0, 4'h0, 1'b0, 2'd0, 32'h0); run += int'(smp[2]);
        cyc('0, 4'h0, 1'b0, 2'd0, 32'h0); run += int'(smp[2]);
        cyc(32'h4, 4'h0, 1'b0, 2'd0, 32'h0); run += int'(smp[2]);
        for (int i = 0; i < 8; i++) begin cyc('0, 4'h0, 1'b0, 2'd0, 32'h0); run += int'(smp[2]); end
        chk_int("R4 high run after retrigger", run, 3 + DELAY);

        // R5: direct line 5 follows its input one cycle late
        tag = "R5";
        dir_v = 32'h0010_0020;
        for (int i = 0; i < 3; i++) cyc(32'h20, 4'h0, 1'b0, 2'd0, 32'h0);
        idle(3);
        chk_vec("R5 released", smp, '0);

        // R7: mask lines 7 and 20; line 7 select 10, line 20 select 11
        tag = "R7";
        wr(2'd0, 32'h0010_0080);
        wr(2'd1, 32'h0000_8000);
        wr(2'd2, 32'h0000_0300);
        idle(1);

        // R6: unselected sources ignored, selected source clears
        tag = "R6";
        cyc(32'h0010_0080, 4'h0, 1'b0, 2'd0, 32'h0);
        idle(DELAY + 2);
        cyc('0, 4'h3, 1'b0, 2'd0, 32'h0);
        idle(1);
        chk_vec("R6 held through unselected pulses", smp, 32'h0010_0080);
        cyc('0, 4'h4, 1'b0, 2'd0, 32'h0);
        idle(1);
        chk_vec("R6 line 7 cleared by timer A", smp, 32'h0010_0000);

        // R8: trigger coinciding with selected clear wins
        tag = "R8";
        cyc(32'h80, 4'h4, 1'b0, 2'd0, 32'h0);
        idle(1);
        chk_vec("R8 trigger priority", smp, 32'h0010_0080);

        // R9: direct masked line 20 ignores release
        tag = "R9";
        cyc(32'h0010_0000, 4'h0, 1'b0, 2'd0, 32'h0);
        idle(4);
        chk_vec("R9 held after release", smp & 32'h0010_0000, 32'h0010_0000);
        cyc('0, 4'hC, 1'b0, 2'd0, 32'h0);
        cyc('0, 4'h4, 1'b0, 2'd0, 32'h0);
        idle(1);
        chk_vec("R9 cleared by timer B", smp, '0);

        // R7: clear-configuration returns line 7 to auto mode
        tag = "R7";
        wr(2'd3, 32'h80);
        cyc(32'h80, 4'h0, 1'b0, 2'd0, 32'h0);
        idle(DELAY + 2);
        chk_vec("R7 line 7 auto after clear", smp, '0);

        // R10: write and trigger in the same cycle use the old config
        tag = "R10";
        dir_v = '0;
        cyc(32'h200, 4'h0, 1'b1, 2'd0, 32'h200);
        idle(DELAY + 3);
        chk_vec("R10 line 9 masked after write", smp, 32'h200);
        cyc('0, 4'h1, 1'b0, 2'd0, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        idle(2);

        // R2: random traffic against the model
        tag = "R2 random";
        for (int blk = 0; blk < 6; blk++) begin
            dir_v = $urandom;
            for (int i = 0; i < 500; i++) begin
                logic w;
                w = ($urandom_range(0, 19) == 0);
                cyc($urandom & $urandom & $urandom, 4'($urandom & $urandom),
                    w, 2'($urandom), $urandom);
            end
        end
        idle(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule